// File: doc/BRIEF.md
# Serial 11011 Pattern Detector

This block watches a one-bit serial stream and flags each place where the bits 1, 1, 0, 1, 1 have just arrived in that order. One bit is taken per rising clock edge, and only when the valid strobe is high. The flag is a Mealy output. It is formed from the present state and the bit currently on the input, so it rises in the same cycle as the bit that completes the pattern. It does not wait for the following edge.

Matches may overlap. The last two bits of one match count as the first two bits of the next. The stream 1,1,0,1,1,0,1,1 therefore gives two hits. The machine has five states held in a three-bit binary-coded register, and a synchronous active-high reset returns it to idle. A typical use is marker or framing detection on a serial link, where the valid strobe marks the cycles that carry real data.

Top module: `pattern_detector_11011`

## Requirements
- R1: While reset is high at a rising edge, the machine returns to idle (state code 000). After reset is released, no hit is reported until five valid bits forming 1,1,0,1,1 have been accepted. The state register only ever holds the codes 000 through 100.
- R2: `match_out` is 1 in exactly the cycles where `serial_valid` is 1, `serial_in` is 1, and the four previously accepted bits since reset were 1,1,0,1, oldest first.
- R3: Overlap is honoured. After a hit the machine behaves as if 1,1 had been seen, so the stream 1,1,0,1,1,0,1,1 hits on its 5th and 8th bits.
- R4: The output is combinational from the state and the present input. With 1,1,0,1 already accepted, changing `serial_in` between clock edges changes `match_out` with no clock edge in between.
- R5: While `serial_valid` is 0, the state does not change and `match_out` is 0. Bits presented without the strobe are ignored.
- R6: A run of more than two ones keeps the "seen 11" progress. The stream 1,1,1,1,0,1,1 hits only on its last bit.
- R7: Reset discards a partly seen pattern and overrides the valid strobe. After 1,1,0,1, a reset, then a single 1, no hit is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| serial_in | input | 1 | Serial data bit |
| serial_valid | input | 1 | High when `serial_in` carries a bit to accept |
| match_out | output | 1 | High in the cycle the pattern completes |

## Verification
Every 10-bit stream is applied from reset with the strobe held high. These streams separate correct overlap re-entry from the wrong fall-back states, and they cover runs of ones and the partial prefixes that must not hit. The same 1024 streams are applied a second time with the strobe dropped on a fixed arithmetic schedule, which shows whether a gated bit leaks into the history. Directed streams cover the double hit, the long run of ones, a reset in the middle of a pattern, and a change of the input between edges, which separates a Mealy output from a registered one.

// File: rtl/pd_pkg.sv
package pd_pkg;

    localparam int unsigned PD_STATE_W = 3;

    typedef enum logic [PD_STATE_W-1:0] {
        PD_IDLE   = 3'b000,
        PD_GOT1   = 3'b001,
        PD_GOT11  = 3'b010,
        PD_GOT110 = 3'b011,
        PD_GOT1101 = 3'b100
    } pd_state_e;

    typedef struct packed {
        logic bit_in;
        logic valid;
    } pd_sample_t;

    // Transition function; any unused code falls back to idle.
    function automatic logic [PD_STATE_W-1:0] pd_step(
        input logic [PD_STATE_W-1:0] cur,
        input logic                  b
    );
        logic [PD_STATE_W-1:0] nxt;
        case (cur)
            PD_IDLE:    nxt = b ? PD_GOT1   : PD_IDLE;
            PD_GOT1:    nxt = b ? PD_GOT11  : PD_IDLE;
            PD_GOT11:   nxt = b ? PD_GOT11  : PD_GOT110;
            PD_GOT110:  nxt = b ? PD_GOT1101 : PD_IDLE;
            PD_GOT1101: nxt = b ? PD_GOT11  : PD_IDLE;
            default:    nxt = PD_IDLE;
        endcase
        return nxt;
    endfunction

    // Output function tied to the completing transition.
    function automatic logic pd_hit(
        input logic [PD_STATE_W-1:0] cur,
        input logic                  b
    );
        return (cur == PD_GOT1101) && b;
    endfunction

endpackage

// File: rtl/pd_state_reg.sv
module pd_state_reg
    import pd_pkg::*;
#(
    parameter int unsigned W = PD_STATE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= W'(PD_IDLE);
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/pd_next_logic.sv
module pd_next_logic
    import pd_pkg::*;
(
    input  logic [PD_STATE_W-1:0] cur,
    input  pd_sample_t            smp,
    output logic [PD_STATE_W-1:0] nxt
);
    always_comb begin
        nxt = pd_step(cur, smp.bit_in);
    end
endmodule

// File: rtl/pd_out_logic.sv
module pd_out_logic
    import pd_pkg::*;
(
    input  logic [PD_STATE_W-1:0] cur,
    input  pd_sample_t            smp,
    output logic                  hit
);
    always_comb begin
        hit = smp.valid && pd_hit(cur, smp.bit_in);
    end
endmodule

// File: rtl/pattern_detector_11011.sv
module pattern_detector_11011
    import pd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic serial_in,
    input  logic serial_valid,
    output logic match_out
);
    logic [PD_STATE_W-1:0] state_q;
    logic [PD_STATE_W-1:0] state_d;
    pd_sample_t            smp;

    always_comb begin
        smp.bit_in = serial_in;
        smp.valid  = serial_valid;
    end

    pd_next_logic u_next (
        .cur (state_q),
        .smp (smp),
        .nxt (state_d)
    );

    pd_state_reg #(.W(PD_STATE_W)) u_reg (
        .clk  (clk),
        .rst  (rst),
        .load (smp.valid),
        .d    (state_d),
        .q    (state_q)
    );

    pd_out_logic u_out (
        .cur (state_q),
        .smp (smp),
        .hit (match_out)
    );
endmodule

// File: rtl/pd_checker.sv
module pd_checker (
    input logic       clk,
    input logic       rst,
    input logic       serial_in,
    input logic       serial_valid,
    input logic       match_out,
    input logic [2:0] state
);
    // R1: reset lands in idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (state == 3'b000));

    // R1: only the five legal codes appear
    assert_state_legal_R1: assert property (@(posedge clk) disable iff (rst)
        state <= 3'b100);

    // R2: a hit needs the 1101 state and a 1 on the input
    assert_hit_source_R2: assert property (@(posedge clk) disable iff (rst)
        match_out |-> (state == 3'b100) && serial_in);

    // R3: after a hit the machine resumes from "seen 11"
    assert_overlap_reentry_R3: assert property (@(posedge clk) disable iff (rst)
        match_out |=> (state == 3'b010));

    // R5: no strobe, no state change
    assert_hold_no_valid_R5: assert property (@(posedge clk) disable iff (rst)
        !serial_valid |=> $stable(state));

    // R5: no strobe, no hit
    assert_quiet_no_valid_R5: assert property (@(posedge clk) disable iff (rst)
        !serial_valid |-> !match_out);
endmodule

bind pattern_detector_11011 pd_checker u_pd_checker (
    .clk          (clk),
    .rst          (rst),
    .serial_in    (serial_in),
    .serial_valid (serial_valid),
    .match_out    (match_out),
    .state        (state_q)
);

// File: tb/test_pattern_detector_11011.sv
`timescale 1ns/1ps
module test_pattern_detector_11011;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic vld = 1'b0;
    logic det;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    logic [3:0]  hist     = 4'b0000;

    always #2 clk = ~clk;

    pattern_detector_11011 i_pattern_detector_11011 (
        .clk          (clk),
        .rst          (rst),
        .serial_in    (din),
        .serial_valid (vld),
        .match_out    (det)
    );

    task automatic check(input logic got, input logic exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: match_out=%b expected=%b at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic model_hit(input logic b, input logic v);
        return v && b && (hist == 4'b1101);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        vld = 1'b0;
        din = 1'b0;
        @(posedge clk);
        hist = 4'b0000;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Apply one bit for one cycle and compare the combinational output.
    task automatic step(input logic b, input logic v, input string req);
        @(negedge clk);
        din = b;
        vld = v;
        #1;
        check(det, model_hit(b, v), req);
        @(posedge clk);
        if (v) hist = {hist[2:0], b};
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: output quiet after reset, a single 1 does not hit
        do_reset();
        #1;
        check(det, 1'b0, "R1 reset state");
        step(1'b1, 1'b1, "R1 first bit after reset");

        // R2: exhaustive 10-bit streams with the strobe always high
        for (int p = 0; p < 1024; p++) begin
            do_reset();
            for (int k = 9; k >= 0; k--) begin
                step(p[k], 1'b1, "R2 sweep");
            end
        end

        // R5: same streams with the strobe gated on a fixed schedule
        for (int p = 0; p < 1024; p++) begin
            do_reset();
            for (int k = 11; k >= 0; k--) begin
                step(p[k % 10], ((k * 3 + p) % 4) != 0, "R5 gated sweep");
            end
        end

        // R3: two overlapping hits, on bits 5 and 8
        do_reset();
        begin
            logic [7:0] s = 8'b11011011;
            for (int k = 7; k >= 0; k--) begin
                step(s[k], 1'b1, "R3 overlap");
            end
        end
        check(hist == 4'b1011 ? 1'b1 : 1'b0, 1'b1, "R3 model sync");

        // R6: long run of ones, hit only at the end
        do_reset();
        begin
            logic [6:0] s = 7'b1111011;
            for (int k = 6; k >= 0; k--) begin
                step(s[k], 1'b1, "R6 run of ones");
            end
        end

        // R7: reset in the middle of a pattern, with the strobe high
        do_reset();
        step(1'b1, 1'b1, "R7 prefix");
        step(1'b1, 1'b1, "R7 prefix");
        step(1'b0, 1'b1, "R7 prefix");
        step(1'b1, 1'b1, "R7 prefix");
        @(negedge clk);
        rst = 1'b1;
        din = 1'b1;
        vld = 1'b1;
        @(posedge clk);
        hist = 4'b0000;
        @(negedge clk);
        rst = 1'b0;
        step(1'b1, 1'b1, "R7 after reset");

        // R4: input changes between edges move the output
        do_reset();
        step(1'b1, 1'b1, "R4 prefix");
        step(1'b1, 1'b1, "R4 prefix");
        step(1'b0, 1'b1, "R4 prefix");
        step(1'b1, 1'b1, "R4 prefix");
        @(negedge clk);
        vld = 1'b1;
        din = 1'b1;
        #0.5;
        check(det, 1'b1, "R4 input high");
        din = 1'b0;
        #0.5;
        check(det, 1'b0, "R4 input low");
        din = 1'b1;
        #0.5;
        check(det, 1'b1, "R4 input high again");
        vld = 1'b0;
        #0.3;
        check(det, 1'b0, "R5 strobe dropped");
        @(posedge clk);
        step(1'b1, 1'b1, "R5 state held");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule